// File: doc/BRIEF.md
# Start-Gap Wear-Leveling Line Remapper

This block sits in front of a memory whose lines wear out with writes. It turns each logical line address into a physical line address so that write traffic spreads evenly over all lines. The memory holds N logical lines and one extra spare line, so it has N+1 physical lines. The mapping needs no table. Two registers set it: a rotation offset and the position of the one empty physical line, called the gap. Translation adds the offset modulo N. If the result is at or above the gap position, it adds one more.

The block counts the write requests it accepts. After a set number of them it holds off new requests and asks an external mover to copy one line into the empty slot next to it. When the mover accepts the command, the gap steps down by one. When the gap has walked down to line 0, the next move wraps it back to the top line and advances the rotation offset. Over time every logical line visits every physical line. The cost is one extra line write per interval: about 1% at the default interval of 100.

Top module: `start_gap_remap`

## Requirements
- R1: After reset the rotation offset is 0, the gap is at physical line N, and the write count is 0. So `physAddr` equals `reqAddr`, `reqReady` is high and `mvValid` is low.
- R2: `physAddr` is `(reqAddr + offset) mod N`, plus one when that value is greater than or equal to the gap position. It is combinational from `reqAddr` and the current state.
- R3: An accepted write (`reqValid`, `reqReady` and `reqWrite` all high) that brings the write count up to the interval raises `mvValid` in the next cycle and clears the write count.
- R4: Accepted reads (`reqWrite` low) and idle cycles do not advance the write count.
- R5: With the gap above 0, the move command has `mvSrc` = gap-1 and `mvDst` = gap. When `mvReady` is taken, the gap decreases by one.
- R6: With the gap at 0, the move command has `mvSrc` = N and `mvDst` = 0. When `mvReady` is taken, the gap becomes N and the offset advances by one modulo N.
- R7: While a move is pending, `reqReady` is low. `mvValid` and the command stay steady until `mvReady` is seen high.
- R8: The interval register resets to 100. A cycle with `cfgWe` high loads `cfgInterval` into it, and later triggers use the new value.
- R9: For every legal logical address, `physAddr` never equals the gap position. Distinct logical addresses map to distinct physical lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle (low while a move is pending) |
| reqWrite | input | 1 | Request is a write |
| reqAddr | input | LA_W | Logical line address, below N |
| physAddr | output | PA_W | Translated physical line address |
| cfgWe | input | 1 | Load a new move interval |
| cfgInterval | input | CNT_W | Move interval, in writes |
| mvValid | output | 1 | Line-move command pending |
| mvReady | input | 1 | Mover accepts the command |
| mvSrc | output | PA_W | Physical line to copy from |
| mvDst | output | PA_W | Physical line to copy into |

## Verification
The assertions assume every `reqAddr` is below N. The gap-exclusion and one-to-one checks depend on that, and the stimulus draws addresses only from 0 to N-1. The assertions also assume the mover never sees a command change under it, which the block itself guarantees by stalling requests. For that reason the bench drives `mvReady` at random, including long low stretches, to test the hold behaviour. A short interval is loaded for the random phase, so the gap wraps through line 0 several times within the run.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef struct packed {
    logic moveBusy;   // a move command is outstanding
    logic commitMove; // mover accepted the command this cycle
  } sgStrobe_t;
endpackage

// File: rtl/sg_datapath.sv
module sg_datapath
  import sg_pkg::*;
#(
  parameter int N = 16,
  parameter int LA_W = $clog2(N),
  parameter int PA_W = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  sgStrobe_t       strobe,
  input  logic [LA_W-1:0] reqAddr,
  output logic [PA_W-1:0] physAddr,
  output logic [PA_W-1:0] mvSrc,
  output logic [PA_W-1:0] mvDst
);
  localparam int EW = PA_W + 1;
  localparam logic [EW-1:0]   NEXT  = EW'(N);
  localparam logic [PA_W-1:0] NTOP  = PA_W'(N);
  localparam logic [LA_W-1:0] SLAST = LA_W'(N - 1);

  logic [LA_W-1:0] startReg;
  logic [PA_W-1:0] gapReg;
  logic [EW-1:0]   rawSum, modSum, shifted;

  always_comb begin
    rawSum  = EW'(reqAddr) + EW'(startReg);
    modSum  = (rawSum >= NEXT) ? rawSum - NEXT : rawSum;
    shifted = (modSum >= EW'(gapReg)) ? modSum + EW'(1) : modSum;
    physAddr = shifted[PA_W-1:0];
  end

  always_comb begin
    if (gapReg == '0) begin
      mvSrc = NTOP;
      mvDst = '0;
    end else begin
      mvSrc = gapReg - PA_W'(1);
      mvDst = gapReg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      startReg <= '0;
      gapReg   <= NTOP;
    end else if (strobe.commitMove) begin
      if (gapReg == '0) begin
        gapReg   <= NTOP;
        startReg <= (startReg == SLAST) ? '0 : startReg + LA_W'(1);
      end else begin
        gapReg <= gapReg - PA_W'(1);
      end
    end
  end

  // R9
  phys_not_gap_chk: assert property (@(posedge clk) disable iff (rst)
    physAddr != gapReg);
  // R5
  gap_step_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.commitMove && gapReg != '0) |=> gapReg == $past(gapReg) - PA_W'(1));
  // R6
  gap_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.commitMove && gapReg == '0) |=>
      (gapReg == NTOP && startReg == (($past(startReg) == SLAST) ? '0 : $past(startReg) + LA_W'(1))));
  // R7
  state_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.commitMove |=> ($stable(gapReg) && $stable(startReg)));
endmodule

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import sg_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int INTERVAL_RST = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic             reqWrite,
  output logic             reqReady,
  input  logic             cfgWe,
  input  logic [CNT_W-1:0] cfgInterval,
  output logic             mvValid,
  input  logic             mvReady,
  output sgStrobe_t        strobe
);
  typedef enum logic {ST_IDLE, ST_MOVE} ctrlState_t;

  ctrlState_t      state;
  logic [CNT_W-1:0] writeCnt, intervalReg;
  logic [CNT_W:0]   cntNext;
  logic             wrAccept, trigger;

  assign reqReady = (state == ST_IDLE);
  assign mvValid  = (state == ST_MOVE);
  assign wrAccept = reqValid && reqReady && reqWrite;
  assign cntNext  = {1'b0, writeCnt} + (CNT_W + 1)'(1);
  assign trigger  = wrAccept && (cntNext >= {1'b0, intervalReg});

  always_comb begin
    strobe.moveBusy   = (state == ST_MOVE);
    strobe.commitMove = (state == ST_MOVE) && mvReady;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intervalReg <= CNT_W'(INTERVAL_RST);
    end else if (cfgWe) begin
      intervalReg <= cfgInterval;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      writeCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (trigger) begin
            state    <= ST_MOVE;
            writeCnt <= '0;
          end else if (wrAccept) begin
            writeCnt <= cntNext[CNT_W-1:0];
          end
        end
        default: begin
          if (mvReady) state <= ST_IDLE;
        end
      endcase
    end
  end

  // R7
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    mvValid |-> !reqReady);
  // R7
  move_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mvValid && !mvReady) |=> mvValid);
  // R3
  move_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mvValid) |-> $past(reqValid && reqWrite));
endmodule

// File: rtl/start_gap_remap.sv
module start_gap_remap
  import sg_pkg::*;
#(
  parameter int N = 16,
  parameter int CNT_W = 8,
  parameter int INTERVAL_RST = 100,
  localparam int LA_W = $clog2(N),
  localparam int PA_W = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [LA_W-1:0]  reqAddr,
  output logic [PA_W-1:0]  physAddr,
  input  logic             cfgWe,
  input  logic [CNT_W-1:0] cfgInterval,
  output logic             mvValid,
  input  logic             mvReady,
  output logic [PA_W-1:0]  mvSrc,
  output logic [PA_W-1:0]  mvDst
);
  sgStrobe_t strobe;

  sg_ctrl #(.CNT_W(CNT_W), .INTERVAL_RST(INTERVAL_RST)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .cfgWe(cfgWe), .cfgInterval(cfgInterval),
    .mvValid(mvValid), .mvReady(mvReady), .strobe(strobe)
  );

  sg_datapath #(.N(N), .LA_W(LA_W), .PA_W(PA_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .reqAddr(reqAddr),
    .physAddr(physAddr), .mvSrc(mvSrc), .mvDst(mvDst)
  );

  // R7
  cmd_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mvValid && !mvReady) |=> ($stable(mvSrc) && $stable(mvDst)));
endmodule

// File: tb/start_gap_remap_tb.sv
module start_gap_remap_tb;
  localparam int N = 16;
  localparam int LA_W = 4;
  localparam int PA_W = 5;
  localparam int CNT_W = 8;

  logic clk = 0, rst = 1;
  logic reqValid = 0, reqWrite = 0, cfgWe = 0, mvReady = 0;
  logic [LA_W-1:0] reqAddr = '0;
  logic [CNT_W-1:0] cfgInterval = '0;
  logic reqReady, mvValid;
  logic [PA_W-1:0] physAddr, mvSrc, mvDst;

  start_gap_remap #(.N(N), .CNT_W(CNT_W), .INTERVAL_RST(100)) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .physAddr(physAddr),
    .cfgWe(cfgWe), .cfgInterval(cfgInterval), .mvValid(mvValid),
    .mvReady(mvReady), .mvSrc(mvSrc), .mvDst(mvDst)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int mStart, mGap, mCnt, mInterval, wraps;
  bit mPending, modelOn = 0, done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int xlate(input int a);
    int s;
    s = (a + mStart) % N;
    return (s >= mGap) ? s + 1 : s;
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    int oldI;
    if (rst) begin
      mStart = 0; mGap = N; mCnt = 0; mInterval = 100; mPending = 0;
    end else begin
      oldI = mInterval;
      if (cfgWe) mInterval = int'(cfgInterval);
      if (mPending) begin
        if (mvReady) begin
          if (mGap == 0) begin
            mGap = N; mStart = (mStart + 1) % N; wraps++;
          end else mGap = mGap - 1;
          mPending = 0;
        end
      end else if (reqValid && reqWrite) begin
        if (mCnt + 1 >= oldI) begin
          mPending = 1; mCnt = 0;
        end else mCnt = mCnt + 1;
      end
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    if (!rst && modelOn) begin
      #1;
      chk(physAddr == PA_W'(xlate(int'(reqAddr))), "R2 physAddr", int'(physAddr), xlate(int'(reqAddr)));
      chk(reqReady == !mPending, "R7 reqReady", int'(reqReady), int'(!mPending));
      chk(mvValid == mPending, "R3 mvValid", int'(mvValid), int'(mPending));
      if (mPending && mvValid) begin
        if (mGap == 0) begin
          chk(mvSrc == PA_W'(N) && mvDst == '0, "R6 move cmd", int'(mvSrc) * 100 + int'(mvDst), N * 100);
        end else begin
          chk(mvSrc == PA_W'(mGap - 1) && mvDst == PA_W'(mGap), "R5 move cmd",
              int'(mvSrc) * 100 + int'(mvDst), (mGap - 1) * 100 + mGap);
        end
      end
    end
  end

  task automatic cyc(input bit v, input bit w, input int a, input bit rdy);
    @(negedge clk);
    reqValid = v; reqWrite = w; reqAddr = LA_W'(a); mvReady = rdy; cfgWe = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    wraps = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    modelOn = 1;
    // R1: reset state seen at the ports
    cyc(0, 0, 5, 0);
    #1;
    chk(reqReady == 1'b1, "R1 reqReady", int'(reqReady), 1);
    chk(mvValid == 1'b0, "R1 mvValid", int'(mvValid), 0);
    chk(physAddr == 5'd5, "R1 identity addr5", int'(physAddr), 5);
    cyc(0, 0, 15, 0);
    #1;
    chk(physAddr == 5'd15, "R1 identity addr15", int'(physAddr), 15);

    // R4: 99 writes interleaved with reads do not reach the default interval
    for (int i = 0; i < 99; i++) begin
      cyc(1, 1, i % N, 0);
      cyc(1, 0, (i * 7) % N, 0);
    end
    cyc(0, 1, 0, 0);
    #1;
    chk(mvValid == 1'b0, "R4 no move after 99 writes", int'(mvValid), 0);
    // R3: the hundredth write triggers
    cyc(1, 1, 3, 0);
    cyc(1, 1, 4, 0);
    #1;
    chk(mvValid == 1'b1, "R3 move raised", int'(mvValid), 1);
    chk(reqReady == 1'b0, "R7 stall", int'(reqReady), 0);
    chk(mvSrc == 5'd15 && mvDst == 5'd16, "R5 first move", int'(mvSrc) * 100 + int'(mvDst), 1516);
    cyc(1, 1, 4, 0);
    cyc(1, 1, 4, 0);
    #1;
    chk(mvValid == 1'b1, "R7 held", int'(mvValid), 1);
    cyc(0, 0, 15, 1);
    cyc(0, 0, 15, 0);
    #1;
    chk(mvValid == 1'b0, "R5 move done", int'(mvValid), 0);
    chk(physAddr == 5'd16, "R5 addr15 skips new gap", int'(physAddr), 16);

    // R8: shorten the interval, then random traffic
    @(negedge clk);
    reqValid = 0; cfgWe = 1; cfgInterval = 8'd3;
    for (int i = 0; i < 3000; i++) begin
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, N - 1),
          $urandom_range(0, 1));
    end
    while (mPending) cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);
    chk(wraps >= 2, "R6 gap wrapped", wraps, 2);
    // R8: with the count freshly zeroed or not, drain exactly to the next move
    while (!mPending) cyc(1, 1, 1, 0);
    cyc(0, 0, 0, 1);
    cyc(1, 1, 2, 0);
    cyc(1, 1, 2, 0);
    cyc(0, 0, 2, 0);
    #1;
    chk(mvValid == 1'b0, "R8 two writes no move", int'(mvValid), 0);
    cyc(1, 1, 2, 0);
    cyc(0, 0, 2, 0);
    #1;
    chk(mvValid == 1'b1, "R8 third write moves", int'(mvValid), 1);
    cyc(0, 0, 0, 1);

    // R9: all logical addresses map to distinct lines, none the gap
    begin
      bit [N:0] seen;
      seen = '0;
      for (int a = 0; a < N; a++) begin
        cyc(0, 0, a, 0);
        #1;
        chk(int'(physAddr) != mGap, "R9 not gap", int'(physAddr), mGap);
        chk(!seen[physAddr], "R9 distinct", int'(physAddr), a);
        seen[physAddr] = 1'b1;
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule